// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block sits in front of a synchronous burst memory and produces the address used for each access. A base address is captured when either of two address strobes is asserted: one driven by the processor side, one by the memory controller side. Both have the same effect. After a capture, the two least significant address bits are sequenced internally by a 2-bit beat counter, which moves forward only in cycles where the advance input is high. The upper address bits keep the value that was captured.

A static order input selects how the beat counter maps onto the low address bits. In linear order the low bits count up by one from the captured value and wrap modulo 4. In interleaved order the low bits are the captured low bits XORed with the beat count. A burst always stays inside its aligned four-word block, and after four advances it comes back to the starting word. Bursting is optional: a new external address can be captured on every cycle with no idle cycles between captures.

The outputs are the current address and the current beat position. Both come straight from registers and an XOR/add on the two low bits. A strobe sampled at a rising edge is visible on the outputs from that edge onward.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied and after it is released with no strobe, `addr_out` is 0 and `beat` is 0.
- R2: If `ld_cpu` or `ld_ctl` (or both) is high at a rising edge, `addr_out` equals the `base_addr` sampled at that edge and `beat` is 0 after that edge. This holds on every cycle, so back-to-back captures each take effect.
- R3: If a strobe and `adv` are high at the same edge, the capture wins: `beat` becomes 0, not the old beat plus one.
- R4: With no strobe at an edge, `addr_out[AW-1:2]` is unchanged across that edge.
- R5: With no strobe and `adv` high at an edge, `beat` becomes the previous beat plus 1 modulo 4. After four advances, `addr_out` returns to the captured address.
- R6: With no strobe and `adv` low at an edge, `addr_out` and `beat` are unchanged.
- R7: When `order_il` is 0 (linear), `addr_out[1:0]` equals the captured low bits plus `beat`, modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R8: When `order_il` is 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR `beat`. For example, a start of 1 gives 1, 0, 3, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_cpu | input | 1 | Processor-side address strobe |
| ld_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Advance the burst by one beat |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| base_addr | input | AW | External address captured on a strobe |
| addr_out | output | AW | Current burst address |
| beat | output | 2 | Current beat position (0 to 3) |

## Verification
The assertions assume that `order_il` is static. More precisely, they assume it changes only while `beat` is 0. At beat 0 both orders give the same address, so such a change cannot move `addr_out`. The stimulus mixes directed bursts with random strobes, advances and addresses in both orders. It changes the order input only when its own reference model shows beat 0, so every step-by-step property holds under the stimulus.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_cpu,
  input  logic          ld_ctl,
  input  logic          adv,
  input  logic          order_il,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  localparam int UW = AW - 2;

  logic [UW-1:0] hi_q;
  logic [1:0]    st_q;
  logic [1:0]    cnt_q;
  logic [1:0]    lo;
  logic          load;

  assign load = ld_cpu | ld_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      st_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      hi_q  <= base_addr[AW-1:2];
      st_q  <= base_addr[1:0];
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign lo       = order_il ? (st_q ^ cnt_q) : (st_q + cnt_q);
  assign addr_out = {hi_q, lo};
  assign beat     = cnt_q;

  // R2 / R3: a capture takes effect at the next edge and clears the beat, even with adv high
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_out == $past(base_addr)) && (beat == 2'd0));

  a_r3_load_beats_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adv) |=> beat == 2'd0);

  // R4: upper bits are untouched between captures
  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[AW-1:2] == $past(addr_out[AW-1:2]));

  // R5: advance moves the beat by one, modulo 4
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> beat == $past(beat) + 2'd1);

  // R6: idle cycles hold the address and the beat
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(addr_out) && $stable(beat));

  // R7: linear order, the low bits increment
  a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!order_il && !load && adv) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  // R8: interleaved order, the low bits flip exactly where the beat count flips
  a_r8_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    (order_il && !load && adv) |=>
      (addr_out[1:0] ^ $past(addr_out[1:0])) == ($past(beat) ^ ($past(beat) + 2'd1)));

  // R1: reset clears the outputs
  a_r1_reset: assert property (@(posedge clk)
    !rst_n |=> (addr_out == '0) && (beat == 2'd0));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_cpu = 1'b0, ld_ctl = 1'b0, adv = 1'b0, order_il = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int checks = 0;
  int errors = 0;

  int m_base = 0;
  int m_cnt  = 0;

  burst_addr_gen #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_cpu(ld_cpu), .ld_ctl(ld_ctl), .adv(adv),
    .order_il(order_il), .base_addr(base_addr), .addr_out(addr_out), .beat(beat)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] expect_addr();
    int lo;
    if (order_il) lo = (m_base % 4) ^ m_cnt;
    else          lo = ((m_base % 4) + m_cnt) % 4;
    return AW'((m_base / 4) * 4 + lo);
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = expect_addr();
    checks++;
    if (addr_out !== ea || beat !== 2'(m_cnt)) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat, ea, m_cnt);
    end
  endtask

  task automatic step(logic lc, logic lt, logic av, logic od,
                      logic [AW-1:0] a, string tag);
    ld_cpu = lc; ld_ctl = lt; adv = av; order_il = od; base_addr = a;
    @(posedge clk);
    if (lc || lt) begin
      m_base = int'(a);
      m_cnt  = 0;
    end else if (av) begin
      m_cnt = (m_cnt + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic od;
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, "R1 after release");

    // R7 linear burst from 2: 2,3,0,1 then wrap back to the start (R5)
    step(1, 0, 0, 0, 20'hABCD2, "R2 cpu load");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 20'h0, "R7 linear / R4 upper");
    checks++;
    if (addr_out !== 20'hABCD2) begin
      errors++;
      $display("FAIL R5 wrap: addr=%h expected addr=%h", addr_out, 20'hABCD2);
    end
    step(0, 0, 0, 0, 20'hFFFFF, "R6 hold");
    step(0, 0, 0, 0, 20'h12345, "R6 hold");

    // R8 interleaved from 1: 1,0,3,2
    step(0, 1, 0, 1, 20'h55551, "R2 ctl load");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 20'h0, "R8 interleaved / R5");
    step(0, 0, 0, 1, 20'h0, "R6 hold");

    // R3 load with advance, in mid-burst
    step(0, 0, 1, 1, 20'h0, "R8");
    step(1, 1, 1, 1, 20'h0F0F3, "R3 load wins");
    step(0, 0, 1, 1, 20'h0, "R8 from 3");

    // R2 back-to-back loads
    for (int i = 0; i < 6; i++)
      step(logic'(i % 2), logic'(i % 2 == 0), 1, 1, AW'(32'h1000 * i + i), "R2 back-to-back");

    // Mixed random traffic; the order input changes only at beat 0
    od = 1'b0;
    for (int i = 0; i < 600; i++) begin
      logic lc, lt, av;
      string tag;
      lc = ($urandom % 6) == 0;
      lt = ($urandom % 6) == 0;
      av = ($urandom % 3) != 0;
      if (m_cnt == 0 && ($urandom % 4) == 0) od = ~od;
      if (lc || lt)    tag = av ? "R3 random" : "R2 random";
      else if (!av)    tag = "R6 random";
      else if (od)     tag = "R8 random";
      else             tag = "R7 random";
      step(lc, lt, av, od, AW'($urandom), tag);
    end

    // R1 reset mid-burst
    rst_n = 1'b0;
    @(posedge clk);
    m_base = 0; m_cnt = 0;
    @(negedge clk);
    check("R1 mid-burst reset");
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule